// File: doc/BRIEF.md
# Stereo Serial Output Port

This block is the serial output stage of a two-channel audio converter. Once per frame it takes a left and a right 16-bit sample from parallel inputs and sends them most-significant bit first on a serial data pin. A frame lasts 64 bit clocks and is cut into four 16-bit slots. The block fills either the first two slots or the last two, so two ports can share one data wire.

Four static format inputs set the behaviour, and any combination is allowed. The first sets where the frame sync sits relative to the first data bit. The second selects master or slave. In master mode the block makes its own bit clock and frame sync. In slave mode it takes both from outside and passes each through synchronising flops. The third selects whether the words sit in the first or second half of the frame. The fourth sets what the data pin does between words: float, or drive low.

A two-bit prescaler select divides the master clock by 1, 2 or 3, or stops all activity. All port logic runs on the divided clock. After reset, or after leaving power-down, the block sends zeros in place of the first 68 words and raises a settling flag while it does so.

Top module: `stereo_sout`

## Requirements
- R1: The clock select `clk_sel_i` works as follows: 01 divides `clk_i` by 1, 10 by 2 and 11 by 3. In master mode `sclk_o` toggles once per divided tick, so one bit-clock period is 2, 4 or 6 `clk_i` cycles.
- R2: With `clk_sel_i` = 00 and from reset, the block is in power-down. In this state `sclk_o`, `sync_o` and `sdo_oe_o` are low and `settling_o` is high. On leaving power-down the block starts again as if just reset.
- R3: A frame is 64 bit-clock periods, numbered 0 to 63. In master mode `sync_o` is high for exactly one bit-clock period in each frame.
- R4: With `sync_late_i` = 0, sync is high during period 63, one bit clock before the first data bit. With `sync_late_i` = 1, sync is high during period 0, together with the first data bit. In master mode `sync_o` changes only together with a falling edge of `sclk_o`.
- R5: With `right_just_i` = 0, the left word fills periods 0 to 15 and the right word fills periods 16 to 31. With `right_just_i` = 1, the left word fills periods 32 to 47 and the right word fills periods 48 to 63. Each word is sent MSB first.
- R6: Inside the word periods, `sdo_oe_o` is 1. Outside them, `sdo_oe_o` is 0 when `drive_low_i` = 0. When `drive_low_i` = 1, `sdo_oe_o` is 1 and `sdo_o` is 0 outside the word periods.
- R7: `sdo_o` and `sdo_oe_o` change only on the divided tick that follows a falling bit-clock edge, and they hold steady over the next rising edge, where a receiver samples them.
- R8: With `slave_i` = 1, `sclk_i` and `sync_i` each pass through two flops clocked by the divided tick. The frame position re-aligns to every rising edge of sync seen at a falling bit-clock edge. `sclk_o` and `sync_o` stay low.
- R9: After reset or power-down, the first 68 words are sent as all zeros and `settling_o` is high. `settling_o` falls on the tick that starts the 69th word, and that word carries real data.
- R10: Both sample inputs are captured on the falling bit-clock edge that begins period 63. They are sent in the frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 2 | Prescaler select: 00 power-down, 01 /1, 10 /2, 11 /3 |
| sync_late_i | input | 1 | Sync phase: 0 one bit early, 1 with first bit |
| slave_i | input | 1 | 0 master, 1 slave |
| right_just_i | input | 1 | 0 words in first half, 1 words in second half |
| drive_low_i | input | 1 | Between words: 0 float, 1 drive low |
| left_word_i | input | 16 | Left-channel sample |
| right_word_i | input | 16 | Right-channel sample |
| sclk_i | input | 1 | Bit clock in slave mode |
| sync_i | input | 1 | Frame sync in slave mode |
| sclk_o | output | 1 | Bit clock in master mode |
| sync_o | output | 1 | Frame sync in master mode |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| settling_o | output | 1 | High while output words are suppressed |

## Verification
The hardest point to reach is the boundary where settling ends. It lies 34 full frames after reset, and its exact position depends on justification. It also depends on how the frame count lines up with the first sync edge, which differs between master and slave modes and between the two sync phases. The bench therefore runs every mode long enough to cross that boundary. It restarts each run from reset, or from power-down, with the first slave sync placed on the very first falling edge. This makes the 34th frame start at a known period. The bench then checks the flag and the first valid word in that frame.

// File: rtl/sout_pkg.sv
package sout_pkg;
  localparam int SLOTS = 4;

  typedef struct packed {
    logic sync_late;
    logic slave;
    logic right_just;
    logic drive_low;
  } fmt_t;
endpackage

// File: rtl/sout_prescale.sv
module sout_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             run_o,
  output logic             tick_o
);
  logic [SEL_W-1:0] cnt_q;

  assign run_o  = (sel_i != '0);
  assign tick_o = run_o && (cnt_q >= sel_i - SEL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_o || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + SEL_W'(1);
  end
endmodule

// File: rtl/sout_clkgen.sv
module sout_clkgen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic slave_i,
  input  logic sclk_i,
  input  logic sync_i,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);
  logic                   sclk_q;
  logic [SYNC_STAGES-1:0] sc_sh, sy_sh;
  logic                   sc_prev, sy_prev;
  logic                   sc_s, sy_s;

  assign sc_s   = sc_sh[SYNC_STAGES-1];
  assign sy_s   = sy_sh[SYNC_STAGES-1];
  assign sclk_o = sclk_q;
  // master: falling edge is the tick that drops sclk_q
  assign fall_o = slave_i ? (tick_i & sc_prev & ~sc_s) : (tick_i & sclk_q);
  assign rise_o = slave_i & fall_o & sy_s & ~sy_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sclk_q <= 1'b0;
    else if (!run_i || slave_i)  sclk_q <= 1'b0;
    else if (tick_i)             sclk_q <= ~sclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_sh   <= '0;
      sy_sh   <= '0;
      sc_prev <= 1'b0;
      sy_prev <= 1'b0;
    end else if (!run_i) begin
      sc_sh   <= '0;
      sy_sh   <= '0;
      sc_prev <= 1'b0;
      sy_prev <= 1'b0;
    end else if (tick_i) begin
      sc_sh   <= {sc_sh[SYNC_STAGES-2:0], sclk_i};
      sy_sh   <= {sy_sh[SYNC_STAGES-2:0], sync_i};
      sc_prev <= sc_s;
      if (fall_o) sy_prev <= sy_s;
    end
  end
endmodule

// File: rtl/sout_framer.sv
module sout_framer
  import sout_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int FRAME_BITS   = 64,
  parameter int SETTLE_WORDS = 68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  fmt_t              fmt_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sync_o,
  output logic              settling_o
);
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int CNT_W = $clog2(SETTLE_WORDS + 1);
  localparam logic [POS_W-1:0] LAST  = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] START = POS_W'(FRAME_BITS - 2);
  localparam logic [POS_W-1:0] HALF  = POS_W'(FRAME_BITS / 2);

  logic [POS_W-1:0]  pos_q, pos_nxt, sync_pos;
  logic [WORD_W-1:0] hold_l, hold_r, cur;
  logic [IDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  cnt_q;
  logic              settling_q, settle_done, settle_nxt;
  logic              in_win, word_start, bit_v;
  logic              sdo_q, oe_q, sync_q;

  always_comb begin
    if (rise_i)             pos_nxt = fmt_i.sync_late ? '0 : LAST;
    else if (pos_q == LAST) pos_nxt = '0;
    else                    pos_nxt = pos_q + POS_W'(1);
  end

  assign sync_pos    = fmt_i.sync_late ? '0 : LAST;
  assign in_win      = fmt_i.right_just ? (pos_nxt >= HALF) : (pos_nxt < HALF);
  assign bit_idx     = pos_nxt[IDX_W-1:0];
  assign cur         = pos_nxt[IDX_W] ? hold_r : hold_l;
  assign bit_v       = cur[IDX_W'(WORD_W - 1) - bit_idx];
  assign word_start  = in_win && (bit_idx == '0);
  assign settle_done = word_start && (cnt_q == CNT_W'(SETTLE_WORDS));
  assign settle_nxt  = settling_q && !settle_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= START;
      hold_l     <= '0;
      hold_r     <= '0;
      cnt_q      <= '0;
      settling_q <= 1'b1;
      sdo_q      <= 1'b0;
      oe_q       <= 1'b0;
      sync_q     <= 1'b0;
    end else if (!run_i) begin
      pos_q      <= START;
      hold_l     <= '0;
      hold_r     <= '0;
      cnt_q      <= '0;
      settling_q <= 1'b1;
      sdo_q      <= 1'b0;
      oe_q       <= 1'b0;
      sync_q     <= 1'b0;
    end else if (fall_i) begin
      pos_q <= pos_nxt;
      if (pos_nxt == LAST) begin
        hold_l <= left_i;
        hold_r <= right_i;
      end
      if (word_start && settling_q && !settle_done) cnt_q <= cnt_q + CNT_W'(1);
      settling_q <= settle_nxt;
      oe_q       <= in_win | fmt_i.drive_low;
      sdo_q      <= in_win & bit_v & ~settle_nxt;
      sync_q     <= !fmt_i.slave && (pos_nxt == sync_pos);
    end
  end

  assign sdo_o      = sdo_q;
  assign sdo_oe_o   = oe_q;
  assign sync_o     = sync_q;
  assign settling_o = settling_q;
endmodule

// File: rtl/stereo_sout.sv
module stereo_sout
  import sout_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int SETTLE_WORDS = 68,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        clk_sel_i,
  input  logic              sync_late_i,
  input  logic              slave_i,
  input  logic              right_just_i,
  input  logic              drive_low_i,
  input  logic [WORD_W-1:0] left_word_i,
  input  logic [WORD_W-1:0] right_word_i,
  input  logic              sclk_i,
  input  logic              sync_i,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              settling_o
);
  localparam int FRAME_BITS = SLOTS * WORD_W;

  logic run, tick, fall, rise;
  fmt_t fmt;

  assign fmt = '{sync_late: sync_late_i, slave: slave_i,
                 right_just: right_just_i, drive_low: drive_low_i};

  sout_prescale #(.SEL_W(2)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (clk_sel_i),
    .run_o (run),
    .tick_o(tick)
  );

  sout_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .run_i  (run),
    .slave_i(slave_i),
    .sclk_i (sclk_i),
    .sync_i (sync_i),
    .sclk_o (sclk_o),
    .fall_o (fall),
    .rise_o (rise)
  );

  sout_framer #(
    .WORD_W      (WORD_W),
    .FRAME_BITS  (FRAME_BITS),
    .SETTLE_WORDS(SETTLE_WORDS)
  ) u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .fall_i    (fall),
    .rise_i    (rise),
    .fmt_i     (fmt),
    .left_i    (left_word_i),
    .right_i   (right_word_i),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .sync_o    (sync_o),
    .settling_o(settling_o)
  );
endmodule

// File: rtl/sout_chk.sv
module sout_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] clk_sel_i,
  input logic       slave_i,
  input logic       drive_low_i,
  input logic       sclk_o,
  input logic       sync_o,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic       settling_o
);
  AST_PD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 2'd0) |=> (!sclk_o && !sdo_oe_o && settling_o)); // R2

  AST_SYNC_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && $rose(sync_o)) |-> $fell(sclk_o)); // R4

  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && !$stable(sdo_o)) |-> ($fell(sclk_o) || $past(clk_sel_i) == 2'd0)); // R7

  AST_IDLE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_low_i && $fell(sdo_oe_o)) |-> ($past(clk_sel_i) == 2'd0)); // R6

  AST_SETTLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settling_o && sdo_oe_o) |-> !sdo_o); // R9

  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_i |-> (!sclk_o && !sync_o)); // R8
endmodule

bind stereo_sout sout_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_sel_i  (clk_sel_i),
  .slave_i    (slave_i),
  .drive_low_i(drive_low_i),
  .sclk_o     (sclk_o),
  .sync_o     (sync_o),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .settling_o (settling_o)
);

// File: tb/stereo_sout_test.sv
`timescale 1ns/1ps
module stereo_sout_test;
  localparam int NF     = 36;
  localparam int SETTLE = 34; // frames of suppressed words (68 words)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'd1;
  logic late = 1'b0, slv = 1'b0, rj = 1'b0, dl = 1'b0;
  logic [15:0] lw = '0, rw = '0;
  logic sclk_in = 1'b1, sync_in = 1'b0;
  logic sclk_o, sync_o, sdo_o, sdo_oe_o, settling_o;

  always #2.5 clk = ~clk;

  stereo_sout uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(sel), .sync_late_i(late),
    .slave_i(slv), .right_just_i(rj), .drive_low_i(dl),
    .left_word_i(lw), .right_word_i(rw), .sclk_i(sclk_in), .sync_i(sync_in),
    .sclk_o(sclk_o), .sync_o(sync_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .settling_o(settling_o)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int f, input bit r);
    case (f % 4)
      0: return r ? 16'h0001 : 16'h8000;
      1: return r ? 16'h0000 : 16'hFFFF;
      default: return 16'((f * 40503 + (r ? 12345 : 0)) ^ 32'h5A5A);
    endcase
  endfunction

  // receiver model
  bit mon_en = 0;
  logic sc, sy, sc_prev = 0, sy_last = 0, have0 = 0, unstable = 0;
  int pos = -1, fidx = 0, last_rise = -1, period = 0, rises = 0;
  logic [63:0] dv, ov, yv, ed, eo;
  logic [15:0] exp_l = '0, exp_r = '0;

  task automatic mon_reset(input logic scp);
    pos = -1; fidx = 0; have0 = 0; sy_last = 0; sc_prev = scp;
    last_rise = -1; unstable = 0;
  endtask

  task automatic frame_check();
    for (int p = 0; p < 64; p++) begin
      logic win;
      logic [15:0] w;
      win = rj ? (p >= 32) : (p < 32);
      w = (((p / 16) % 2) == 1) ? exp_r : exp_l;
      eo[p] = win | dl;
      ed[p] = win & (fidx >= SETTLE) & w[15 - (p % 16)];
    end
    check(ov == eo, "R6 output enable pattern", ov, eo);
    if (fidx >= SETTLE) check((dv & eo) == ed, "R5 R10 frame data", dv & eo, ed);
    else                check((dv & eo) == ed, "R9 suppressed data", dv & eo, ed);
    check(!unstable, "R7 sdo steady while sclk high", 64'(unstable), 64'd0);
    if (!slv) check(yv == (late ? 64'h1 : 64'h8000_0000_0000_0000),
                    "R3 R4 sync position", yv, late ? 64'h1 : 64'h8000_0000_0000_0000);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      sc = slv ? sclk_in : sclk_o;
      sy = slv ? sync_in : sync_o;
      if (sc && !sc_prev) begin
        rises++;
        if (last_rise >= 0) period = cyc - last_rise;
        last_rise = cyc;
        if (sy && !sy_last) pos = late ? 0 : 63;
        else if (pos >= 0)  pos = (pos + 1) % 64;
        sy_last = sy;
        if (pos >= 0) begin
          if (pos == 0) begin
            have0 = 1; dv = '0; ov = '0; yv = '0; unstable = 0;
          end
          dv[pos] = sdo_o; ov[pos] = sdo_oe_o; yv[pos] = sy;
          if (have0 && pos == (rj ? 32 : 0))
            check(settling_o == (fidx < SETTLE), "R9 settling flag",
                  64'(settling_o), 64'(fidx < SETTLE));
          if (pos == 16) begin
            lw = pat(fidx, 0);
            rw = pat(fidx, 1);
          end
          if (pos == 63) begin
            if (have0) begin
              frame_check();
              fidx++;
            end
            exp_l = lw;
            exp_r = rw;
          end
        end
      end else if (sc && pos >= 0 && have0) begin
        if (sdo_o !== dv[pos] || sdo_oe_o !== ov[pos]) unstable = 1;
      end
      sc_prev = sc;
    end
  end

  task automatic drive_slave(input int half);
    int q;
    q = late ? 0 : 63;
    repeat (4) @(posedge clk);
    for (int i = 0; i < (NF + 1) * 64; i++) begin
      @(posedge clk); #1;
      sclk_in = 1'b0;
      sync_in = (q == (late ? 0 : 63));
      repeat (half - 1) @(posedge clk);
      #1 sclk_in = 1'b1;
      repeat (half - 1) @(posedge clk);
      q = (q + 1) % 64;
    end
  endtask

  task automatic run_test(input logic [1:0] s, input logic lt, input logic sl,
                          input logic r, input logic d);
    mon_en = 0;
    rst_n = 0;
    sel = s; late = lt; slv = sl; rj = r; dl = d;
    sclk_in = 1'b1; sync_in = 1'b0;
    repeat (4) @(posedge clk); #1;
    check(!sdo_oe_o && settling_o && !sclk_o && !sync_o, "R2 R9 reset state",
          {60'd0, sdo_oe_o, settling_o, sclk_o, sync_o}, 64'h4);
    mon_reset(sl);
    mon_en = 1;
    rst_n = 1;
    if (sl) begin
      drive_slave(6);
      check(fidx >= NF, "R8 slave frames aligned", 64'(fidx), 64'(NF));
      check(!sclk_o && !sync_o, "R8 slave pins idle", {62'd0, sclk_o, sync_o}, 64'd0);
    end else begin
      wait (fidx >= NF);
      check(period == 2 * int'(s), "R1 sclk period", 64'(period), 64'(2 * int'(s)));
    end
  endtask

  task automatic pd_test();
    int r0;
    run_test(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    sel = 2'd0;
    repeat (3) @(posedge clk); #1;
    r0 = rises;
    repeat (100) @(posedge clk); #1;
    check(rises == r0 && !sclk_o && !sdo_oe_o && settling_o, "R2 power-down quiet",
          {61'd0, sclk_o, sdo_oe_o, settling_o}, 64'h1);
    mon_en = 0;
    mon_reset(1'b0);
    mon_en = 1;
    sel = 2'd1;
    wait (fidx >= NF);
    check(period == 2, "R1 R2 restart after power-down", 64'(period), 64'd2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    run_test(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_test(2'd2, 1'b1, 1'b0, 1'b1, 1'b1);
    run_test(2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    run_test(2'd1, 1'b1, 1'b1, 1'b0, 1'b1);
    run_test(2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    pd_test();
    mon_en = 0;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule